// File: doc/BRIEF.md
# SPI Slave Byte Shifter

This block is the target side of a four-wire serial peripheral link. An external master owns the serial clock and the select line. While select is held low, the block gathers one byte from the master-out line and, over the same clock edges, drives a byte prepared beforehand onto the master-in line. Clock idle level, clock phase and bit order are inputs, and they must match the settings of the master.

The serial clock, the select line and the master-out data are brought into the system clock domain through synchronizer stages. Edges of the serial clock are then found by comparison with the previous synchronized value. The system clock must run at least four times faster than the serial clock. Status appears in the system clock domain. A busy flag covers each byte in flight. When a byte completes, the block raises a sticky "byte received" flag and a one-cycle interrupt pulse. A read strobe clears the flag. If select rises before the eighth bit, the byte is dropped without status.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, `active_o`, `rx_byte_o`, `rx_irq_o`, `miso_oe_o`, `miso_o` are 0 and `rx_data_o` is 0.
- R2: `miso_oe_o` is 1 exactly while the synchronized select is low (two system clocks after `ss_ni` changes), and `miso_o` is 0 whenever `miso_oe_o` is 0.
- R3: The leading SCK edge is the transition away from the idle level `cfg_cpol_i`. Data is sampled on the leading edge when `cfg_cpha_i`=0 and on the trailing edge when it is 1. After eight sample edges, `rx_data_o` holds the byte sent, in all four clock modes.
- R4: With `cfg_lsb_first_i`=1 the first bit on the wire is bit 0 of the byte. With 0 it is bit 7.
- R5: Bit k of the transmit sequence (same ordering rule as R4) is valid on `miso_o` at the k-th sample edge. With `cfg_cpha_i`=0 the first bit is driven as soon as the output enables, before any SCK edge.
- R6: `active_o` rises three system clocks after `ss_ni` falls and drops in the cycle the eighth sample completes.
- R7: On completion, `rx_data_o` updates, `rx_byte_o` sets and `rx_irq_o` pulses for exactly one cycle, all in the same cycle.
- R8: If select rises before the eighth sample, `active_o` clears, and no flag, no interrupt and no change of `rx_data_o` result.
- R9: A one-cycle `rx_read_i` clears `rx_byte_o` on the next cycle. A completion in the same cycle keeps the flag set.
- R10: SCK edges after the eighth sample while select stays low are ignored. A new byte needs select to go high and then low again.
- R11: `tx_byte_i` is captured when select falls. Changes to it during the transfer do not alter `miso_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cpol_i | input | 1 | SCK idle level |
| cfg_cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first_i | input | 1 | 1: bit 0 first on the wire |
| tx_byte_i | input | DATA_W | Byte to send in the next transfer |
| rx_read_i | input | 1 | Read strobe, clears the received flag |
| sck_i | input | 1 | Serial clock from master |
| ss_ni | input | 1 | Select from master, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output driver enable for miso_o (0 = high impedance) |
| active_o | output | 1 | Byte in progress |
| rx_byte_o | output | 1 | Received-byte flag |
| rx_irq_o | output | 1 | One-cycle receive interrupt |
| rx_data_o | output | DATA_W | Last completed byte |

## Verification
The hardest situations to reach are the ones where select timing and clock edges interact. These are a select rise after only a few bits, SCK pulses that continue after the eighth sample, and a read strobe that is still high when a byte completes. The bench drives a master task that can stop early, add extra clock pulses, swap the transmit byte halfway through or hold the read strobe across a whole transfer. A behavioural model delays the bench's own input history by the synchronizer depth and predicts the status outputs on every clock.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    // clock mode handed to the edge classifier
    typedef struct packed {
        logic idle_high;   // SCK level while idle
        logic late_sample; // sample on trailing edge
    } spi_mode_t;

    localparam int unsigned SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned    WIDTH   = 1,
    parameter int unsigned    STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= RST_VAL;
            else         stage_q[g] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_edge.sv
module spi_edge
    import spi_slv_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  spi_mode_t mode_i,
    input  logic      sck_i,     // already synchronized
    output logic      sample_o,  // capture MOSI here
    output logic      shift_o    // advance MISO here
);

    logic prev_d, prev_q;
    logic rise, fall, lead, trail;

    always_comb begin
        prev_d = sck_i;
        rise   = sck_i & ~prev_q;
        fall   = ~sck_i & prev_q;
        lead   = mode_i.idle_high ? fall : rise;
        trail  = mode_i.idle_high ? rise : fall;
    end

    assign sample_o = mode_i.late_sample ? trail : lead;
    assign shift_o  = mode_i.late_sample ? lead  : trail;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

endmodule

// File: rtl/spi_tx_pick.sv
module spi_tx_pick #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic              lsb_first_i,
    output logic              bit_o
);

    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] idx_c;
    logic [IDX_W-1:0] pos;

    always_comb begin
        idx_c = (idx_i > LAST) ? LAST : idx_i;
        pos   = lsb_first_i ? idx_c[IDX_W-1:0]
                            : IDX_W'(DATA_W - 1) - idx_c[IDX_W-1:0];
        bit_o = data_i[pos];
    end

endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
    import spi_slv_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_cpol_i,
    input  logic              cfg_cpha_i,
    input  logic              cfg_lsb_first_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              rx_read_i,
    input  logic              sck_i,
    input  logic              ss_ni,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              active_o,
    output logic              rx_byte_o,
    output logic              rx_irq_o,
    output logic [DATA_W-1:0] rx_data_o
);

    localparam int unsigned CNT_W = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DATA_W);

    typedef struct packed {
        logic              active;
        logic              done;     // byte finished, wait for select release
        logic [CNT_W-1:0]  smp_cnt;  // sample edges seen
        logic [CNT_W-1:0]  sh_cnt;   // shift edges seen
        logic [DATA_W-1:0] rx_sr;
        logic [DATA_W-1:0] rx_data;
        logic              rx_flag;
        logic              irq;
        logic [DATA_W-1:0] tx_hold;
    } state_t;

    state_t st_d, st_q;

    logic      ss_s, sck_s, mosi_s;
    logic      sample_e, shift_e;
    logic      tx_bit;
    spi_mode_t mode;
    logic [CNT_W-1:0] tx_idx;
    logic [DATA_W-1:0] rx_next;

    assign mode = '{idle_high: cfg_cpol_i, late_sample: cfg_cpha_i};

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({ss_ni, sck_i, mosi_i}),
        .q_o   ({ss_s, sck_s, mosi_s})
    );

    spi_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode_i  (mode),
        .sck_i   (sck_s),
        .sample_o(sample_e),
        .shift_o (shift_e)
    );

    // with late sampling the first shift edge presents bit 0
    assign tx_idx = (cfg_cpha_i && st_q.sh_cnt != '0) ? st_q.sh_cnt - 1'b1
                                                      : st_q.sh_cnt;

    spi_tx_pick #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_pick (
        .data_i     (st_q.tx_hold),
        .idx_i      (tx_idx),
        .lsb_first_i(cfg_lsb_first_i),
        .bit_o      (tx_bit)
    );

    always_comb begin
        rx_next = cfg_lsb_first_i ? {mosi_s, st_q.rx_sr[DATA_W-1:1]}
                                  : {st_q.rx_sr[DATA_W-2:0], mosi_s};
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (rx_read_i) st_d.rx_flag = 1'b0;

        if (ss_s) begin
            // deselected: abandon any partial byte, track next tx byte
            st_d.active  = 1'b0;
            st_d.done    = 1'b0;
            st_d.smp_cnt = '0;
            st_d.sh_cnt  = '0;
            st_d.tx_hold = tx_byte_i;
        end else if (!st_q.done) begin
            st_d.active = 1'b1;
            if (shift_e && st_q.sh_cnt != CNT_MAX) begin
                st_d.sh_cnt = st_q.sh_cnt + 1'b1;
            end
            if (sample_e) begin
                st_d.rx_sr   = rx_next;
                st_d.smp_cnt = st_q.smp_cnt + 1'b1;
                if (st_q.smp_cnt == LAST_BIT) begin
                    st_d.active  = 1'b0;
                    st_d.done    = 1'b1;
                    st_d.rx_data = rx_next;
                    st_d.rx_flag = 1'b1;
                    st_d.irq     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign miso_oe_o = ~ss_s;
    assign miso_o    = ~ss_s & tx_bit;
    assign active_o  = st_q.active;
    assign rx_byte_o = st_q.rx_flag;
    assign rx_irq_o  = st_q.irq;
    assign rx_data_o = st_q.rx_data;

endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rx_read_i,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic              active_o,
    input logic              rx_byte_o,
    input logic              rx_irq_o,
    input logic [DATA_W-1:0] rx_data_o
);

    p_oe_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !miso_oe_o |-> !miso_o);

    p_irq_ends_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_irq_o |-> (!active_o && $past(active_o)));

    p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_irq_o |=> !rx_irq_o);

    p_irq_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_irq_o |-> rx_byte_o);

    p_flag_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rx_byte_o) |-> rx_irq_o);

    p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_irq_o |-> $stable(rx_data_o));

    p_read_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_read_i |=> (!rx_byte_o || rx_irq_o));

endmodule

bind spi_byte_slave spi_byte_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_read_i(rx_read_i),
    .miso_o   (miso_o),
    .miso_oe_o(miso_oe_o),
    .active_o (active_o),
    .rx_byte_o(rx_byte_o),
    .rx_irq_o (rx_irq_o),
    .rx_data_o(rx_data_o)
);

// File: tb/spi_byte_slave_test.sv
module spi_byte_slave_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_read = 1'b0;
    logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso, miso_oe, active, rx_byte, rx_irq;
    logic [7:0] rx_data;

    int tests = 0;
    int fails = 0;
    int irq_seen = 0;

    always #5 clk = ~clk;

    spi_byte_slave uut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .cfg_cpol_i     (cpol),
        .cfg_cpha_i     (cpha),
        .cfg_lsb_first_i(lsb),
        .tx_byte_i      (tx_byte),
        .rx_read_i      (rx_read),
        .sck_i          (sck),
        .ss_ni          (ss_n),
        .mosi_i         (mosi),
        .miso_o         (miso),
        .miso_oe_o      (miso_oe),
        .active_o       (active),
        .rx_byte_o      (rx_byte),
        .rx_irq_o       (rx_irq),
        .rx_data_o      (rx_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference, stepped once per clock ----
    bit c_rst = 0, c_ss = 1, c_sck = 0, c_mosi = 0, c_read = 0, c_pol = 0, c_pha = 0, c_lsb = 0;
    bit hq_ss[$];
    bit hq_sck[$];
    bit hq_mosi[$];
    bit m_prev = 0, m_active = 0, m_done = 0, m_flag = 0, m_irq = 0;
    int m_cnt = 0, m_sr = 0, m_data = 0;

    always @(negedge clk) begin
        bit s_ss, s_sck, s_mosi, edge_seen, lead, samp, exp_oe;
        if (!c_rst) begin
            hq_ss.delete(); hq_sck.delete(); hq_mosi.delete();
            m_prev = 0; m_active = 0; m_done = 0; m_flag = 0; m_irq = 0;
            m_cnt = 0; m_sr = 0; m_data = 0;
        end else begin
            hq_ss.push_back(c_ss); hq_sck.push_back(c_sck); hq_mosi.push_back(c_mosi);
            if (hq_ss.size() == 3) begin
                s_ss = hq_ss.pop_front(); s_sck = hq_sck.pop_front(); s_mosi = hq_mosi.pop_front();
            end else begin
                s_ss = 1; s_sck = 0; s_mosi = 0;
            end
            m_irq = 0;
            if (c_read) m_flag = 0;
            edge_seen = (s_sck != m_prev);
            lead = edge_seen && (s_sck != c_pol);
            samp = c_pha ? (edge_seen && !lead) : lead;
            m_prev = s_sck;
            if (s_ss) begin
                m_active = 0; m_done = 0; m_cnt = 0;
            end else if (!m_done) begin
                m_active = 1;
                if (samp) begin
                    if (c_lsb) m_sr = (int'(s_mosi) << 7) | (m_sr >> 1);
                    else       m_sr = ((m_sr << 1) | int'(s_mosi)) & 8'hFF;
                    m_cnt++;
                    if (m_cnt == 8) begin
                        m_done = 1; m_active = 0; m_data = m_sr; m_flag = 1; m_irq = 1;
                    end
                end
            end
        end
        exp_oe = (hq_ss.size() == 2) ? !hq_ss[0] : 1'b0;
        if (rst_n && c_rst) begin
            chk("R6 active", int'(active), int'(m_active));
            chk("R7/R9 rx_byte", int'(rx_byte), int'(m_flag));
            chk("R7 rx_irq", int'(rx_irq), int'(m_irq));
            chk("R3 rx_data", int'(rx_data), m_data);
            chk("R2 miso_oe", int'(miso_oe), int'(exp_oe));
            if (!miso_oe) chk("R2 miso idle", int'(miso), 0);
        end
        if (rst_n && rx_irq) irq_seen++;
        c_rst = rst_n; c_ss = ss_n; c_sck = sck; c_mosi = mosi; c_read = rx_read;
        c_pol = cpol; c_pha = cpha; c_lsb = lsb;
    end

    // ---------------- master-side stimulus ------------------------------
    task automatic clks(input int n);
        repeat (n) begin
            @(posedge clk);
            #3;
        end
    endtask

    task automatic xfer(input bit pol, input bit pha, input bit first_lsb,
                        input logic [7:0] tx, input logic [7:0] rx,
                        input int nbits, input int extra,
                        input bit swap_tx, input logic [7:0] tx2);
        cpol = pol; cpha = pha; lsb = first_lsb; sck = pol; tx_byte = tx;
        clks(6);
        ss_n = 1'b0;
        clks(4);
        chk("R2 enable", int'(miso_oe), 1);
        for (int i = 0; i < nbits; i++) begin
            bit mb, eb;
            mb = first_lsb ? rx[i] : rx[7-i];
            eb = first_lsb ? tx[i] : tx[7-i];
            if (swap_tx && i == 3) tx_byte = tx2;   // R11
            if (!pha) begin
                mosi = mb; clks(2);
                chk(swap_tx ? "R11 miso bit" : "R5 miso bit", int'(miso), int'(eb));
                sck = ~pol; clks(4);
                sck = pol;  clks(2);
            end else begin
                sck = ~pol; mosi = mb; clks(4);
                chk(swap_tx ? "R11 miso bit" : "R5 miso bit", int'(miso), int'(eb));
                sck = pol;  clks(4);
            end
        end
        for (int j = 0; j < extra; j++) begin
            mosi = ~mosi;
            sck = ~pol; clks(4);
            sck = pol;  clks(4);
        end
        clks(4);
        ss_n = 1'b1;
        clks(6);
    endtask

    initial begin
        #2000000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int irq0;
        clks(3);
        chk("R1 active", int'(active), 0);
        chk("R1 rx_byte", int'(rx_byte), 0);
        chk("R1 rx_irq", int'(rx_irq), 0);
        chk("R1 miso_oe", int'(miso_oe), 0);
        chk("R1 rx_data", int'(rx_data), 0);
        rst_n = 1'b1;
        clks(5);

        // four clock modes, both orders (R3, R4, R5)
        xfer(0, 0, 0, 8'hA5, 8'h3C, 8, 0, 0, 8'h00);
        chk("R3 mode0 data", int'(rx_data), 8'h3C);
        chk("R7 flag", int'(rx_byte), 1);
        xfer(0, 1, 1, 8'h96, 8'h81, 8, 0, 0, 8'h00);
        chk("R4 lsb-first data", int'(rx_data), 8'h81);
        xfer(1, 0, 0, 8'h5B, 8'hE7, 8, 0, 0, 8'h00);
        chk("R3 mode2 data", int'(rx_data), 8'hE7);
        xfer(1, 1, 1, 8'h0F, 8'h01, 8, 0, 0, 8'h00);
        chk("R4 bit0 first", int'(rx_data), 8'h01);

        // read strobe clears flag (R9)
        rx_read = 1'b1; clks(1); rx_read = 1'b0; clks(1);
        chk("R9 cleared", int'(rx_byte), 0);

        // abort after five bits (R8)
        irq0 = irq_seen;
        xfer(0, 0, 0, 8'hFF, 8'h55, 5, 0, 0, 8'h00);
        chk("R8 no flag", int'(rx_byte), 0);
        chk("R8 no irq", irq_seen - irq0, 0);
        chk("R8 data kept", int'(rx_data), 8'h01);

        // extra pulses after the byte are ignored (R10)
        irq0 = irq_seen;
        xfer(0, 1, 0, 8'hC3, 8'h6A, 8, 3, 0, 8'h00);
        chk("R10 one irq", irq_seen - irq0, 1);
        chk("R10 data", int'(rx_data), 8'h6A);

        // tx byte changed mid-transfer (R11)
        xfer(1, 0, 1, 8'h3A, 8'h99, 8, 0, 1, 8'hC5);
        chk("R11 rx intact", int'(rx_data), 8'h99);

        // read held across completion (R9): flag clears right after
        rx_read = 1'b1;
        xfer(0, 0, 1, 8'h12, 8'hB4, 8, 0, 0, 8'h00);
        rx_read = 1'b0; clks(1);
        chk("R9 held read", int'(rx_byte), 0);
        chk("R9 data", int'(rx_data), 8'hB4);

        clks(4);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule